// File: doc/BRIEF.md
# Super I/O Configuration Unlock Port

This block implements a legacy configuration port pair on a byte-wide I/O bus: one address selects an index register, the other a data register. The port starts locked. Software opens it by writing a fixed four-byte key to the index port. The last byte of that key depends on which of the two standard base addresses the port is strapped to, and a parameter selects that address. Once the port is open, an index write picks a configuration register and data-port accesses read or write that register.

The register set is small. It holds a read-only chip identity and a revision byte, a logical-device select, and a global flash-control register whose upper bits are masked off. Logical device 7 holds the 16-bit base address of a serial-flash command port. The block drives that base and the flash-control bits straight out to the neighbouring command engine. Writing the exit value to the exit register closes the port again, and software must present the full key before it can reach the registers a second time.

Top module: `sio_cfg_port`

## Requirements
- R1: After synchronous reset the port is locked (`cfg_open` = 0), `rvalid` is 0, `flash_ctrl` equals FCTL_RST (default 0) and `flash_base` equals FBASE_RST (default 0x0820).
- R2: While locked, four consecutive index-port writes of 0x87, 0x01, 0x55 and a last byte unlock the port, and `cfg_open` is high in the cycle after the last write. The last byte is 0x55 when PORT_BASE is 0x2E and 0xAA when PORT_BASE is 0x4E, and the other value does not unlock.
- R3: A byte that does not match the expected key step sends the matcher back to its first step, except that a mismatching byte equal to 0x87 counts as the first step of a new attempt.
- R4: While locked, reads of either port return 0xFF, and data-port writes change no register and no output.
- R5: A read strobe (`rd_en`) returns its byte on `rdata` with `rvalid` high exactly one cycle later, and `rvalid` is low in any cycle that follows a cycle without `rd_en`.
- R6: Registers 0x20 and 0x21 return the high and low bytes of CHIP_ID (default 0x8716), and register 0x22 returns CHIP_REV (default 0x02). Writes to these three registers are ignored.
- R7: Register 0x07 is an 8-bit read/write logical-device select.
- R8: Register 0x24 stores its low FCTL_BITS bits (default 6: bit 0 suspend, bits 1 to 3 segment enables, bit 4 flash write enable, bit 5 pin select). Upper bits read as 0, and the stored bits drive `flash_ctrl`.
- R9: Registers 0x64 (high byte) and 0x65 (low byte) of the flash command port base are reachable only while the logical-device select is 7. They are then readable and writable, and `flash_base` follows them one cycle after the write. With any other device selected, they read 0xFF and writes are ignored.
- R10: A data write of exactly 0x02 to register 0x02 locks the port in the next cycle. Any other value written there leaves the port open.
- R11: While open, an index-port read returns the current index. Unimplemented registers read 0xFF and register 0x02 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| rvalid | output | 1 | High one cycle after `rd_en` |
| cfg_open | output | 1 | Configuration port unlocked |
| flash_base | output | 16 | Serial-flash command port base address |
| flash_ctrl | output | FCTL_BITS | Stored flash-control bits |

## Verification
A key matcher stuck on the wrong step shows up within four index writes: either `cfg_open` fails to rise on a valid key, or it rises on a broken one. A stale lock state shows on the very next data read as 0xFF where a register value was expected, or the reverse. A register-decode or masking fault shows on the read one cycle after the strobe, or on `flash_base` or `flash_ctrl` one cycle after the offending write. The logical-device gating of the base registers is checked on both sides of the select, because a missing gate leaves `flash_base` altered after a write made under the wrong device.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int DW = 8;

  // unlock key, first three bytes are common to both base addresses
  localparam logic [DW-1:0] KEY_B0     = 8'h87;
  localparam logic [DW-1:0] KEY_B1     = 8'h01;
  localparam logic [DW-1:0] KEY_B2     = 8'h55;
  localparam logic [DW-1:0] KEY_LAST_A = 8'h55;
  localparam logic [DW-1:0] KEY_LAST_B = 8'hAA;
  localparam logic [15:0]   BASE_A     = 16'h002E;
  localparam logic [15:0]   BASE_B     = 16'h004E;

  // configuration register indices
  localparam logic [DW-1:0] IDX_EXIT  = 8'h02;
  localparam logic [DW-1:0] IDX_LDN   = 8'h07;
  localparam logic [DW-1:0] IDX_IDHI  = 8'h20;
  localparam logic [DW-1:0] IDX_IDLO  = 8'h21;
  localparam logic [DW-1:0] IDX_REV   = 8'h22;
  localparam logic [DW-1:0] IDX_FCTL  = 8'h24;
  localparam logic [DW-1:0] IDX_FBHI  = 8'h64;
  localparam logic [DW-1:0] IDX_FBLO  = 8'h65;

  localparam logic [DW-1:0] EXIT_VAL  = 8'h02;
  localparam logic [DW-1:0] FLASH_LDN = 8'h07;
  localparam logic [DW-1:0] RD_FLOAT  = 8'hFF;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_ONE  = 2'd1,
    KS_TWO  = 2'd2,
    KS_THREE = 2'd3
  } key_step_t;

  typedef enum logic {
    SEL_INDEX = 1'b0,
    SEL_DATA  = 1'b1
  } port_sel_t;

  function automatic logic [DW-1:0] key_expect(key_step_t s, logic [DW-1:0] last);
    case (s)
      KS_IDLE:  key_expect = KEY_B0;
      KS_ONE:   key_expect = KEY_B1;
      KS_TWO:   key_expect = KEY_B2;
      default:  key_expect = last;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_keymatch.sv
module sio_cfg_keymatch
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] PORT_BASE = 16'h002E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_wr,
  input  logic [DW-1:0] key_byte,
  input  logic          relock,
  output logic          open_q
);

  logic [DW-1:0] last_byte;
  key_step_t     step_q;
  logic [DW-1:0] expect_b;

  // the base address strap picks the final key byte
  generate
    if (PORT_BASE == BASE_A) begin : g_base_a
      assign last_byte = KEY_LAST_A;
    end else begin : g_base_b
      assign last_byte = KEY_LAST_B;
    end
  endgenerate

  assign expect_b = key_expect(step_q, last_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= KS_IDLE;
      open_q <= 1'b0;
    end else if (relock) begin
      step_q <= KS_IDLE;
      open_q <= 1'b0;
    end else if (key_wr && !open_q) begin
      if (key_byte == expect_b) begin
        if (step_q == KS_THREE) begin
          open_q <= 1'b1;
          step_q <= KS_IDLE;
        end else begin
          step_q <= key_step_t'(step_q + 2'd1);
        end
      end else if (key_byte == KEY_B0) begin
        step_q <= KS_ONE;
      end else begin
        step_q <= KS_IDLE;
      end
    end
  end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [7:0]  CHIP_REV  = 8'h02,
  parameter logic [15:0] FBASE_RST = 16'h0820,
  parameter int          FCTL_BITS = 6,
  parameter logic [FCTL_BITS-1:0] FCTL_RST = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 open_q,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 port_sel,
  input  logic [DW-1:0]        wdata,
  output logic                 relock,
  output logic [DW-1:0]        rdata,
  output logic                 rvalid,
  output logic [DW-1:0]        cur_index,
  output logic [DW-1:0]        cur_ldn,
  output logic [2*DW-1:0]      fbase,
  output logic [FCTL_BITS-1:0] fctl
);

  logic [DW-1:0]        idx_q;
  logic [DW-1:0]        ldn_q;
  logic [FCTL_BITS-1:0] fctl_q;
  logic [DW-1:0]        fb_hi_q;
  logic [DW-1:0]        fb_lo_q;
  logic                 idx_wr;
  logic                 dat_wr;
  logic                 ldn_hit;
  logic [DW-1:0]        fctl_ext;
  logic [DW-1:0]        rd_next;
  logic [DW-1:0]        rdata_q;
  logic                 rvalid_q;

  assign idx_wr  = open_q && wr_en && (port_sel == SEL_INDEX);
  assign dat_wr  = open_q && wr_en && (port_sel == SEL_DATA);
  assign ldn_hit = (ldn_q == FLASH_LDN);
  assign relock  = dat_wr && (idx_q == IDX_EXIT) && (wdata == EXIT_VAL);

  always_comb begin
    fctl_ext = '0;
    fctl_ext[FCTL_BITS-1:0] = fctl_q;
  end

  // register storage; identity registers have no storage at all
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      ldn_q   <= '0;
      fctl_q  <= FCTL_RST;
      fb_hi_q <= FBASE_RST[2*DW-1:DW];
      fb_lo_q <= FBASE_RST[DW-1:0];
    end else begin
      if (idx_wr) begin
        idx_q <= wdata;
      end
      if (dat_wr) begin
        case (idx_q)
          IDX_LDN:  ldn_q  <= wdata;
          IDX_FCTL: fctl_q <= wdata[FCTL_BITS-1:0];
          IDX_FBHI: if (ldn_hit) fb_hi_q <= wdata;
          IDX_FBLO: if (ldn_hit) fb_lo_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  // read decode
  always_comb begin
    rd_next = RD_FLOAT;
    if (open_q) begin
      if (port_sel == SEL_INDEX) begin
        rd_next = idx_q;
      end else begin
        case (idx_q)
          IDX_EXIT: rd_next = '0;
          IDX_LDN:  rd_next = ldn_q;
          IDX_IDHI: rd_next = CHIP_ID[2*DW-1:DW];
          IDX_IDLO: rd_next = CHIP_ID[DW-1:0];
          IDX_REV:  rd_next = CHIP_REV;
          IDX_FCTL: rd_next = fctl_ext;
          IDX_FBHI: rd_next = ldn_hit ? fb_hi_q : RD_FLOAT;
          IDX_FBLO: rd_next = ldn_hit ? fb_lo_q : RD_FLOAT;
          default:  rd_next = RD_FLOAT;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) begin
        rdata_q <= rd_next;
      end
    end
  end

  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;
  assign cur_index = idx_q;
  assign cur_ldn   = ldn_q;
  assign fbase     = {fb_hi_q, fb_lo_q};
  assign fctl      = fctl_q;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] PORT_BASE = 16'h002E,
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [7:0]  CHIP_REV  = 8'h02,
  parameter logic [15:0] FBASE_RST = 16'h0820,
  parameter int          FCTL_BITS = 6,
  parameter logic [FCTL_BITS-1:0] FCTL_RST = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 port_sel,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 rvalid,
  output logic                 cfg_open,
  output logic [15:0]          flash_base,
  output logic [FCTL_BITS-1:0] flash_ctrl
);

  logic          relock;
  logic          key_wr;
  logic [DW-1:0] cur_index;
  logic [DW-1:0] cur_ldn;

  assign key_wr = wr_en && (port_sel == SEL_INDEX);

  sio_cfg_keymatch #(
    .PORT_BASE (PORT_BASE)
  ) u_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .key_byte (wdata),
    .relock   (relock),
    .open_q   (cfg_open)
  );

  sio_cfg_regs #(
    .CHIP_ID   (CHIP_ID),
    .CHIP_REV  (CHIP_REV),
    .FBASE_RST (FBASE_RST),
    .FCTL_BITS (FCTL_BITS),
    .FCTL_RST  (FCTL_RST)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .open_q    (cfg_open),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_sel  (port_sel),
    .wdata     (wdata),
    .relock    (relock),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .cur_index (cur_index),
    .cur_ldn   (cur_ldn),
    .fbase     (flash_base),
    .fctl      (flash_ctrl)
  );

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] PORT_BASE = 16'h002E,
  parameter int          FCTL_BITS = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic                 port_sel,
  input logic [7:0]           wdata,
  input logic [7:0]           rdata,
  input logic                 rvalid,
  input logic                 cfg_open,
  input logic [15:0]          flash_base,
  input logic [FCTL_BITS-1:0] flash_ctrl,
  input logic [7:0]           cur_index,
  input logic [7:0]           cur_ldn
);

  localparam logic [7:0] LAST_KEY = (PORT_BASE == BASE_A) ? KEY_LAST_A : KEY_LAST_B;

  // R2: opening is always caused by the final key byte on the index port
  p_open_by_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(wr_en && !port_sel && wdata == LAST_KEY));

  // R4: locked reads float high
  p_locked_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && rd_en) |=> (rdata == 8'hFF));

  // R4: nothing reaches the outputs while locked
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> ($stable(flash_base) && $stable(flash_ctrl)));

  // R5: read response one cycle after the strobe
  p_rd_latency_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  // R5: no response without a strobe
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);

  // R9: base registers are gated by the device select
  p_ldn_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (cur_ldn != 8'h07) |=> $stable(flash_base));

  // R10: closing only follows the exit write
  p_relock_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_open) |-> $past(wr_en && port_sel && wdata == 8'h02 && cur_index == 8'h02));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .PORT_BASE (PORT_BASE),
  .FCTL_BITS (FCTL_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .port_sel   (port_sel),
  .wdata      (wdata),
  .rdata      (rdata),
  .rvalid     (rvalid),
  .cfg_open   (cfg_open),
  .flash_base (flash_base),
  .flash_ctrl (flash_ctrl),
  .cur_index  (cur_index),
  .cur_ldn    (cur_ldn)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr0 = 1'b0, rd0 = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
  logic       psel = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata0, rdata1;
  logic       rvalid0, rvalid1, open0, open1;
  logic [15:0] fbase0, fbase1;
  logic [5:0] fctl0, fctl1;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sio_cfg_port #(.PORT_BASE(16'h002E)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr0), .rd_en(rd0), .port_sel(psel),
    .wdata(wd), .rdata(rdata0), .rvalid(rvalid0), .cfg_open(open0),
    .flash_base(fbase0), .flash_ctrl(fctl0)
  );

  sio_cfg_port #(.PORT_BASE(16'h004E)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr1), .rd_en(rd1), .port_sel(psel),
    .wdata(wd), .rdata(rdata1), .rvalid(rvalid1), .cfg_open(open1),
    .flash_base(fbase1), .flash_ctrl(fctl1)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int d, logic ps, logic [7:0] v);
    @(negedge clk);
    psel = ps; wd = v;
    if (d == 0) wr0 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(int d, logic ps, output logic [7:0] v);
    @(negedge clk);
    psel = ps;
    if (d == 0) rd0 = 1'b1; else rd1 = 1'b1;
    @(negedge clk);
    rd0 = 1'b0; rd1 = 1'b0;
    v = (d == 0) ? rdata0 : rdata1;
    chk("R5 rvalid", {15'd0, (d == 0) ? rvalid0 : rvalid1}, 16'd1);
  endtask

  task automatic reg_rd(int d, logic [7:0] idx, output logic [7:0] v);
    wr(d, 1'b0, idx);
    rd(d, 1'b1, v);
  endtask

  task automatic key4(int d, logic [7:0] last);
    wr(d, 1'b0, 8'h87);
    wr(d, 1'b0, 8'h01);
    wr(d, 1'b0, 8'h55);
    wr(d, 1'b0, last);
  endtask

  task automatic t_reset();
    chk("R1 open", {15'd0, open0}, 16'd0);
    chk("R1 rvalid", {15'd0, rvalid0}, 16'd0);
    chk("R1 fbase", fbase0, 16'h0820);
    chk("R1 fctl", {10'd0, fctl0}, 16'd0);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    rd(0, 1'b1, v);
    chk("R4 locked data read", {8'd0, v}, 16'h00FF);
    rd(0, 1'b0, v);
    chk("R4 locked index read", {8'd0, v}, 16'h00FF);
    wr(0, 1'b0, 8'h24);
    wr(0, 1'b1, 8'h3F);
    chk("R4 locked write fctl", {10'd0, fctl0}, 16'd0);
    @(negedge clk);
    chk("R5 rvalid idle", {15'd0, rvalid0}, 16'd0);
  endtask

  task automatic t_bad_keys();
    wr(0, 1'b0, 8'h87); wr(0, 1'b0, 8'h01); wr(0, 1'b0, 8'h00);
    wr(0, 1'b0, 8'h55); wr(0, 1'b0, 8'h55);
    chk("R3 broken key stays locked", {15'd0, open0}, 16'd0);
    key4(0, 8'hAA);
    chk("R2 wrong last byte for 0x2E", {15'd0, open0}, 16'd0);
  endtask

  task automatic t_restart_unlock();
    wr(0, 1'b0, 8'h87); wr(0, 1'b0, 8'h01); wr(0, 1'b0, 8'h87);
    chk("R3 not yet open", {15'd0, open0}, 16'd0);
    wr(0, 1'b0, 8'h01); wr(0, 1'b0, 8'h55); wr(0, 1'b0, 8'h55);
    chk("R3 R2 restart on 0x87 then unlock", {15'd0, open0}, 16'd1);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    reg_rd(0, 8'h20, v);
    chk("R6 id high", {8'd0, v}, 16'h0087);
    rd(0, 1'b0, v);
    chk("R11 index readback", {8'd0, v}, 16'h0020);
    reg_rd(0, 8'h21, v);
    chk("R6 id low", {8'd0, v}, 16'h0016);
    reg_rd(0, 8'h22, v);
    chk("R6 revision", {8'd0, v}, 16'h0002);
    wr(0, 1'b0, 8'h20); wr(0, 1'b1, 8'h00);
    rd(0, 1'b1, v);
    chk("R6 id read-only", {8'd0, v}, 16'h0087);
    reg_rd(0, 8'h30, v);
    chk("R11 unimplemented", {8'd0, v}, 16'h00FF);
    reg_rd(0, 8'h02, v);
    chk("R11 exit reg reads zero", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_flash_base();
    logic [7:0] v;
    reg_rd(0, 8'h64, v);
    chk("R9 gated read", {8'd0, v}, 16'h00FF);
    wr(0, 1'b1, 8'h12);
    chk("R9 gated write ignored", fbase0, 16'h0820);
    wr(0, 1'b0, 8'h07); wr(0, 1'b1, 8'h07);
    rd(0, 1'b1, v);
    chk("R7 ldn readback", {8'd0, v}, 16'h0007);
    reg_rd(0, 8'h64, v);
    chk("R9 base high default", {8'd0, v}, 16'h0008);
    wr(0, 1'b1, 8'h0A);
    wr(0, 1'b0, 8'h65); wr(0, 1'b1, 8'h10);
    chk("R9 base output", fbase0, 16'h0A10);
    rd(0, 1'b1, v);
    chk("R9 base low readback", {8'd0, v}, 16'h0010);
    wr(0, 1'b0, 8'h07); wr(0, 1'b1, 8'h03);
    rd(0, 1'b1, v);
    chk("R7 ldn rewrite", {8'd0, v}, 16'h0003);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(0, 1'b0, 8'h24); wr(0, 1'b1, 8'hFF);
    chk("R8 fctl output", {10'd0, fctl0}, 16'h003F);
    rd(0, 1'b1, v);
    chk("R8 masked readback", {8'd0, v}, 16'h003F);
    wr(0, 1'b1, 8'h12);
    chk("R8 fctl update", {10'd0, fctl0}, 16'h0012);
  endtask

  task automatic t_relock();
    logic [7:0] v;
    wr(0, 1'b0, 8'h02); wr(0, 1'b1, 8'h01);
    chk("R10 other value keeps open", {15'd0, open0}, 16'd1);
    wr(0, 1'b1, 8'h02);
    chk("R10 exit locks", {15'd0, open0}, 16'd0);
    rd(0, 1'b1, v);
    chk("R4 read after relock", {8'd0, v}, 16'h00FF);
    @(negedge clk);
    chk("R5 rvalid drops", {15'd0, rvalid0}, 16'd0);
    wr(0, 1'b0, 8'h24); wr(0, 1'b1, 8'h00);
    chk("R4 write after relock ignored", {10'd0, fctl0}, 16'h0012);
  endtask

  task automatic t_alt_base();
    logic [7:0] v;
    key4(1, 8'h55);
    chk("R2 0x4E rejects 0x55", {15'd0, open1}, 16'd0);
    key4(1, 8'hAA);
    chk("R2 0x4E accepts 0xAA", {15'd0, open1}, 16'd1);
    reg_rd(1, 8'h21, v);
    chk("R6 id low on 0x4E", {8'd0, v}, 16'h0016);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_locked();
    t_bad_keys();
    t_restart_unlock();
    t_ident();
    t_flash_base();
    t_ctrl();
    t_relock();
    t_alt_base();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule